// File: doc/BRIEF.md
# MSI Ring-Buffer Capture Controller

This block takes in message-signalled interrupt writes, each carrying a 16-bit vector number. It turns every accepted message into a 16-byte record and issues that record as one memory write request into a circular buffer in system memory. Software sets up the block through a small word-addressed register bank. It sets the buffer base address, picks one of four ring sizes, and sets the enable and full-policy bits. It then consumes records by advancing a read offset that it writes back to the block.

The block keeps a hardware write offset that wraps cleanly inside the selected ring. It detects a full ring, and depending on a policy bit it either drops new messages and records a sticky overflow flag, or overwrites the oldest record. A single level interrupt tells the host that unread records exist. Only one record is in flight at a time, and the message input is back-pressured while that record waits for the memory side.

Top module: `msi_ring_capture`

## Requirements
- R1: After reset every register reads zero, `irq` is low and `mem_req_valid` is low.
- R2: The register word addresses are control 0, base-high 3, base-low 4, read offset 5 and write offset 6. The write offset is read-only, and writes to it are ignored. Control bits are: 0 enable, 1 full handling, 3 interrupt enable, 4 stop-on-full, 9:8 size code, and 16 sticky overflow (reads 1 when set; writing 1 there clears it).
- R3: Each record is sent as one request. Its address is the 64-bit base ({base-high, base-low}) plus the write offset. Its 128-bit payload holds the vector in bits 15:0 and zeros in every other bit.
- R4: The write offset changes only when a request is accepted (`mem_req_valid` and `mem_req_ready` both high). It then advances by 16 and wraps modulo the ring size of 2^(15+size code) bytes.
- R5: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid and its address and payload stay unchanged.
- R6: With full handling and stop-on-full set, a message arriving when (write offset + 16) mod size equals the read offset is dropped. No request is issued and the overflow bit becomes 1 and stays set until it is cleared.
- R7: With full handling set and stop-on-full clear, a message on a full ring is written. When that request is accepted, the read offset also advances by 16.
- R8: With full handling clear, the ring is never treated as full. Records are written and the read offset is left untouched.
- R9: `irq` is a registered copy of (enable and interrupt enable and write offset ≠ read offset). It falls one cycle after the read offset is written equal to the write offset.
- R10: While enable is clear, incoming messages are consumed and discarded. No request is issued and the overflow bit does not change.
- R11: While enable is set, writes to base-high, base-low and the size code are ignored.
- R12: A written read offset is masked to the current ring size and forced to 16-byte alignment.
- R13: `msi_ready` is low while a request is outstanding and high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register word address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| msi_valid | input | 1 | Incoming message present |
| msi_ready | output | 1 | Block can take a message |
| msi_vector | input | 16 | Interrupt vector number of the message |
| mem_req_valid | output | 1 | Memory write request valid |
| mem_req_ready | input | 1 | Memory side accepts the request |
| mem_req_addr | output | 64 | Byte address of the record |
| mem_req_data | output | 128 | Record payload |
| irq | output | 1 | Host interrupt, level |

## Verification
The latencies are fixed. A message taken at edge E shows up as a request right after E. An accepted request moves the write offset at the accepting edge, and `irq` follows one edge later. A register write lands at its edge, and `reg_rdata` shows it from the next falling edge on. The bench drives and samples only on falling edges, and it counts edges to these points before every check. For example, after a read-offset write it samples `irq` at the first falling edge, where it must still be high, and again at the second, where it must be low. Requests are checked at the falling edge after capture. Dropped messages are checked by watching for two falling edges that `mem_req_valid` stays low.

// File: rtl/msir_pkg.sv
package msir_pkg;
  localparam int MIN_SHIFT  = 15;
  localparam int SIZE_CODES = 4;
  localparam int CODE_W     = $clog2(SIZE_CODES);
  localparam int OFF_W      = MIN_SHIFT + SIZE_CODES - 1;
  localparam int ENTRY_B    = 16;
  localparam int REG_W      = 32;
  localparam int RA_W       = 3;
  localparam int ADDR_W     = 64;
  localparam int DATA_W     = 128;
  localparam int VEC_W      = 16;

  localparam logic [RA_W-1:0] RA_CTRL = 3'd0;
  localparam logic [RA_W-1:0] RA_BHI  = 3'd3;
  localparam logic [RA_W-1:0] RA_BLO  = 3'd4;
  localparam logic [RA_W-1:0] RA_RD   = 3'd5;
  localparam logic [RA_W-1:0] RA_WR   = 3'd6;

  localparam int B_EN   = 0;
  localparam int B_FULL = 1;
  localparam int B_IRQ  = 3;
  localparam int B_STOP = 4;
  localparam int B_SIZE = 8;
  localparam int B_OVF  = 16;

  typedef struct packed {
    logic              ovf;
    logic [CODE_W-1:0] size;
    logic              stop;
    logic              irqen;
    logic              fullen;
    logic              en;
  } ctrl_t;

  // Offset mask for a given size code: ring bytes minus one, 16-byte aligned.
  function automatic logic [OFF_W-1:0] ring_mask(input logic [CODE_W-1:0] code);
    logic [OFF_W:0] ring_bytes;
    ring_bytes = (OFF_W+1)'(1) << (MIN_SHIFT + 32'(code));
    return OFF_W'(ring_bytes - 1'b1) & ~OFF_W'(ENTRY_B - 1);
  endfunction

  // Offset of the following record, wrapped into the ring.
  function automatic logic [OFF_W-1:0] ring_next(input logic [OFF_W-1:0] off,
                                                 input logic [CODE_W-1:0] code);
    return (off + OFF_W'(ENTRY_B)) & ring_mask(code);
  endfunction
endpackage

// File: rtl/msir_regs.sv
module msir_regs
  import msir_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic [OFF_W-1:0]  woff,
  input  logic              rd_bump,
  input  logic              ovf_set,
  output ctrl_t             ctrl,
  output logic [ADDR_W-1:0] base,
  output logic [OFF_W-1:0]  roff,
  output logic [REG_W-1:0]  reg_rdata
);
  logic [REG_W-1:0] base_hi, base_lo;
  logic wr_ctrl, wr_bhi, wr_blo, wr_rd;

  assign wr_ctrl = reg_wr && (reg_addr == RA_CTRL);
  assign wr_bhi  = reg_wr && (reg_addr == RA_BHI) && !ctrl.en;
  assign wr_blo  = reg_wr && (reg_addr == RA_BLO) && !ctrl.en;
  assign wr_rd   = reg_wr && (reg_addr == RA_RD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl    <= '0;
      base_hi <= '0;
      base_lo <= '0;
      roff    <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl.en     <= reg_wdata[B_EN];
        ctrl.fullen <= reg_wdata[B_FULL];
        ctrl.irqen  <= reg_wdata[B_IRQ];
        ctrl.stop   <= reg_wdata[B_STOP];
        if (!ctrl.en) ctrl.size <= reg_wdata[B_SIZE +: CODE_W];
      end
      if (ovf_set)                          ctrl.ovf <= 1'b1;
      else if (wr_ctrl && reg_wdata[B_OVF]) ctrl.ovf <= 1'b0;
      if (wr_bhi) base_hi <= reg_wdata;
      if (wr_blo) base_lo <= reg_wdata;
      if (wr_rd)        roff <= reg_wdata[OFF_W-1:0] & ring_mask(ctrl.size);
      else if (rd_bump) roff <= ring_next(roff, ctrl.size);
    end
  end

  assign base = {base_hi, base_lo};

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      RA_CTRL: begin
        reg_rdata[B_EN]   = ctrl.en;
        reg_rdata[B_FULL] = ctrl.fullen;
        reg_rdata[B_IRQ]  = ctrl.irqen;
        reg_rdata[B_STOP] = ctrl.stop;
        reg_rdata[B_SIZE +: CODE_W] = ctrl.size;
        reg_rdata[B_OVF]  = ctrl.ovf;
      end
      RA_BHI:  reg_rdata = base_hi;
      RA_BLO:  reg_rdata = base_lo;
      RA_RD:   reg_rdata = REG_W'(roff);
      RA_WR:   reg_rdata = REG_W'(woff);
      default: reg_rdata = '0;
    endcase
  end

  p_lock_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.en && reg_wr && (reg_addr == RA_BLO)) |=> $stable(base_lo));
  p_lock_size_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.en |=> $stable(ctrl.size));
  p_rd_align_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (roff & ~ring_mask(ctrl.size)) == '0);
endmodule

// File: rtl/msir_ring.sv
module msir_ring
  import msir_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              fullen,
  input  logic              stop,
  input  logic [CODE_W-1:0] size,
  input  logic [OFF_W-1:0]  roff,
  input  logic              msi_valid,
  input  logic              slot_free,
  input  logic              mem_accept,
  output logic [OFF_W-1:0]  woff,
  output logic              take,
  output logic              drop,
  output logic              rd_bump
);
  logic             fire, ring_full;
  logic [OFF_W-1:0] woff_nx;

  assign woff_nx   = ring_next(woff, size);
  assign ring_full = fullen && (woff_nx == roff);
  assign fire      = msi_valid && slot_free && en;
  assign drop      = fire && ring_full && stop;
  assign take      = fire && !drop;
  assign rd_bump   = mem_accept && ring_full && !stop;

  always_ff @(posedge clk) begin
    if (!rst_n)          woff <= '0;
    else if (mem_accept) woff <= woff_nx;
  end

  p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_accept |=> $stable(woff));
  p_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
    woff[3:0] == 4'd0);
  p_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !take && !drop);
endmodule

// File: rtl/msir_req.sv
module msir_req
  import msir_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [VEC_W-1:0]  vector,
  input  logic [ADDR_W-1:0] rec_addr,
  input  logic              mem_ready,
  output logic              mem_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic              slot_free,
  output logic              accept
);
  localparam int PAD_W = DATA_W - VEC_W;

  assign slot_free = !mem_valid;
  assign accept    = mem_valid && mem_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_valid <= 1'b0;
      mem_addr  <= '0;
      mem_data  <= '0;
    end else if (take) begin
      mem_valid <= 1'b1;
      mem_addr  <= rec_addr;
      mem_data  <= {{PAD_W{1'b0}}, vector};
    end else if (accept) begin
      mem_valid <= 1'b0;
    end
  end

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> mem_valid && $stable(mem_addr) && $stable(mem_data));
endmodule

// File: rtl/msi_ring_capture.sv
module msi_ring_capture
  import msir_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              msi_valid,
  output logic              msi_ready,
  input  logic [15:0]       msi_vector,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [63:0]       mem_req_addr,
  output logic [127:0]      mem_req_data,
  output logic              irq
);
  ctrl_t             ctrl;
  logic [ADDR_W-1:0] base;
  logic [OFF_W-1:0]  roff, woff;
  logic              take, drop, rd_bump, accept, slot_free;
  logic [ADDR_W-1:0] rec_addr;

  assign rec_addr  = base + ADDR_W'(woff);
  assign msi_ready = slot_free;

  msir_regs u_regs (
    .clk, .rst_n, .reg_addr, .reg_wr, .reg_wdata,
    .woff, .rd_bump, .ovf_set(drop),
    .ctrl, .base, .roff, .reg_rdata
  );

  msir_ring u_ring (
    .clk, .rst_n,
    .en(ctrl.en), .fullen(ctrl.fullen), .stop(ctrl.stop), .size(ctrl.size),
    .roff, .msi_valid, .slot_free, .mem_accept(accept),
    .woff, .take, .drop, .rd_bump
  );

  msir_req u_req (
    .clk, .rst_n, .take, .vector(msi_vector), .rec_addr,
    .mem_ready(mem_req_ready), .mem_valid(mem_req_valid),
    .mem_addr(mem_req_addr), .mem_data(mem_req_data),
    .slot_free, .accept
  );

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= ctrl.en && ctrl.irqen && (woff != roff);
  end

  p_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (woff == roff) |=> !irq);
  p_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> ctrl.ovf && !mem_req_valid);
  p_ready_r13: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !msi_ready);
  p_pad_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_data[127:16] == '0);
endmodule

// File: tb/test_msi_ring_capture.sv
module test_msi_ring_capture;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   reg_addr = '0;
  logic         reg_wr = 1'b0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic         msi_valid = 1'b0;
  logic         msi_ready;
  logic [15:0]  msi_vector = '0;
  logic         mem_req_valid;
  logic         mem_req_ready = 1'b1;
  logic [63:0]  mem_req_addr;
  logic [127:0] mem_req_data;
  logic         irq;

  int n_chk = 0;
  int n_bad = 0;
  logic [63:0] base_v;

  always #4 clk = ~clk;

  msi_ring_capture i_msi_ring_capture (.*);

  task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    #1;
    chk(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  // One message; with exp_req, expects its request right after capture.
  task automatic send(input logic [15:0] v, input bit exp_req, input logic [63:0] exp_addr);
    @(negedge clk);
    while (!msi_ready) @(negedge clk);
    msi_valid = 1'b1; msi_vector = v;
    @(negedge clk);
    msi_valid = 1'b0;
    if (exp_req) begin
      chk(mem_req_valid, "R3 request issued", mem_req_valid, 1);
      chk(mem_req_addr == exp_addr, "R3 address", mem_req_addr, exp_addr);
      chk(mem_req_data == {112'd0, v}, "R3 payload", mem_req_data, {112'd0, v});
      @(negedge clk);
      chk(!mem_req_valid, "R4 accepted", mem_req_valid, 0);
    end else begin
      chk(!mem_req_valid, "R6/R10 no request", mem_req_valid, 0);
      @(negedge clk);
      chk(!mem_req_valid, "R6/R10 no request later", mem_req_valid, 0);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    rd_chk(3'd0, 0, "R1 ctrl");
    rd_chk(3'd3, 0, "R1 base hi");
    rd_chk(3'd4, 0, "R1 base lo");
    rd_chk(3'd5, 0, "R1 read off");
    rd_chk(3'd6, 0, "R1 write off");
    chk(!irq, "R1 irq", irq, 0);
    chk(!mem_req_valid, "R1 valid", mem_req_valid, 0);
    chk(msi_ready, "R13 idle ready", msi_ready, 1);
  endtask

  task automatic t_regs;
    wr(3'd3, 32'h1);
    wr(3'd4, 32'h8000_0000);
    wr(3'd0, 32'h100);
    rd_chk(3'd3, 32'h1, "R2 base hi");
    rd_chk(3'd4, 32'h8000_0000, "R2 base lo");
    rd_chk(3'd0, 32'h100, "R2 ctrl size");
    wr(3'd5, 32'h0001_2345);
    rd_chk(3'd5, 32'h2340, "R12 masked read offset");
    wr(3'd6, 32'h40);
    rd_chk(3'd6, 0, "R2 write offset read-only");
    wr(3'd5, 0);
    base_v = 64'h1_8000_0000;
  endtask

  task automatic t_disabled;
    send(16'h55, 1'b0, 0);
    rd_chk(3'd6, 0, "R10 offset unchanged");
    rd_chk(3'd0, 32'h100, "R10 no overflow");
  endtask

  task automatic t_basic;
    wr(3'd0, 32'h109);
    mem_req_ready = 1'b0;
    @(negedge clk);
    msi_valid = 1'b1; msi_vector = 16'hABCD;
    @(negedge clk);
    msi_valid = 1'b0;
    chk(mem_req_valid, "R3 valid", mem_req_valid, 1);
    chk(mem_req_addr == base_v, "R3 address", mem_req_addr, base_v);
    chk(mem_req_data == 128'hABCD, "R3 payload", mem_req_data, 128'hABCD);
    chk(!msi_ready, "R13 busy", msi_ready, 0);
    repeat (3) @(negedge clk);
    chk(mem_req_valid && mem_req_addr == base_v && mem_req_data == 128'hABCD,
        "R5 held", mem_req_valid, 1);
    rd_chk(3'd6, 0, "R4 no advance while stalled");
    mem_req_ready = 1'b1;
    @(negedge clk);
    rd_chk(3'd6, 16, "R4 advance on accept");
    chk(msi_ready, "R13 free again", msi_ready, 1);
    @(negedge clk);
    chk(irq, "R9 irq raised", irq, 1);
    wr(3'd5, 16);
    chk(irq, "R9 irq still high one cycle", irq, 1);
    @(negedge clk);
    chk(!irq, "R9 irq dropped", irq, 0);
  endtask

  task automatic t_locked;
    wr(3'd4, 32'hDEAD_0000);
    rd_chk(3'd4, 32'h8000_0000, "R11 base lo locked");
    wr(3'd3, 32'h7);
    rd_chk(3'd3, 32'h1, "R11 base hi locked");
    wr(3'd0, 32'h309);
    rd_chk(3'd0, 32'h109, "R11 size locked");
  endtask

  task automatic t_wrap_full;
    wr(3'd0, 32'h100);
    wr(3'd0, 32'h01B);
    rd_chk(3'd0, 32'h01B, "R2 ctrl bits");
    for (int i = 0; i < 2047; i++)
      send(16'(i), 1'b1, base_v + 64'((16 + 16 * i) & 32'h7FF0));
    rd_chk(3'd6, 0, "R4 wrap to zero");
    send(16'h77, 1'b0, 0);
    rd_chk(3'd6, 0, "R6 offset held when full");
    rd_chk(3'd0, 32'h1001B, "R6 overflow set");
    wr(3'd0, 32'h1000B);
    rd_chk(3'd0, 32'h0000B, "R6 overflow cleared");
    send(16'h88, 1'b1, base_v);
    rd_chk(3'd6, 16, "R7 written");
    rd_chk(3'd5, 32, "R7 read offset pushed");
    wr(3'd0, 32'h009);
    send(16'h99, 1'b1, base_v + 16);
    rd_chk(3'd6, 32, "R8 written");
    rd_chk(3'd5, 32, "R8 read offset kept");
    @(negedge clk);
    chk(!irq, "R9 empty ring no irq", irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_disabled();
    t_basic();
    t_locked();
    t_wrap_full();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule